// File: doc/BRIEF.md
# Timer Output Compare Unit

This unit watches an external free-running 16-bit timer and compares it with a compare register that software loads. When the timer first reaches the compare value, the unit acts according to a 4-bit mode field. It can force its output pin high or low, raise only an interrupt flag, or raise the flag together with a one-cycle trigger pulse. The timer uses that pulse to clear itself to zero.

Every input here is a plain control or status pin. The unit has no data stream, so there is no valid/ready handshake and no back-pressure. The mode and compare registers are loaded by single-cycle write strobes. The interrupt flag stays set until software clears it with `flag_clr`. Mode `0000` switches the unit off: it holds the pin low and the flag clear. Mode values outside `0000` and `10xx` perform no compare action.

Top module: `tmr_cmp_unit`

## Requirements
- R1: After reset, `pin_out`, `irq_flag` and `evt_trig` are 0, the mode register is `0000` and the compare register is 0.
- R2: In mode `1000`, a match sets `pin_out` to 1 and `irq_flag` to 1 on the clock edge that follows the first cycle in which `tmr_val` equals the compare value.
- R3: In mode `1001`, a match clears `pin_out` to 0 and sets `irq_flag` on that same edge.
- R4: In mode `1010`, a match sets `irq_flag` only, and `pin_out` keeps its value.
- R5: In mode `1011`, a match sets `irq_flag` and drives `evt_trig` high for exactly one cycle, and `pin_out` keeps its value.
- R6: A match acts only once, on the first cycle of equality. While the equality persists, it neither sets the flag again nor pulses the trigger again.
- R7: While the mode register holds `0000`, `pin_out` is driven low, `irq_flag` is cleared and matches have no effect. This takes hold from the edge after the mode write.
- R8: Mode values other than `0000` and `1000` to `1011` take no action on a match, and `pin_out` and `irq_flag` keep their values.
- R9: `flag_clr` clears `irq_flag` on the next edge. A match that acts on the same edge takes priority, and the flag ends up set.
- R10: A compare-register write takes effect from the next cycle's comparison. The write itself does not change `pin_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tmr_val | input | 16 | Current value of the external timer |
| cmp_wr_en | input | 1 | Strobe that loads the compare register |
| cmp_wr_data | input | 16 | New compare value |
| mode_wr_en | input | 1 | Strobe that loads the mode register |
| mode_wr_data | input | 4 | New mode value |
| flag_clr | input | 1 | Clears the interrupt flag |
| pin_out | output | 1 | Compare output pin |
| irq_flag | output | 1 | Sticky interrupt flag |
| evt_trig | output | 1 | One-cycle special-event pulse that resets the timer |

## Verification
A stale match-history bit has two possible effects, both visible one cycle after the first equal timer value. It can drop an action, so `irq_flag` stays low. Or it can repeat an action during a held equality, so the flag returns right after a clear or `evt_trig` is high for two cycles. A wrong mode decode shows on the next match as a pin driven to the wrong level, or as a pin that moves in a mode that should hold it. A compare register that resets or loads incorrectly shows when an expected match edge produces no flag. Every outputs is registered, so each fault appears exactly one edge after the cycle that caused it.

// File: rtl/tcu_pkg.sv
package tcu_pkg;
  localparam int MODE_W = 4;

  typedef enum logic [MODE_W-1:0] {
    MD_OFF = 4'b0000,
    MD_SET = 4'b1000,
    MD_CLR = 4'b1001,
    MD_SWI = 4'b1010,
    MD_EVT = 4'b1011
  } tcu_mode_e;

  typedef struct packed {
    logic force_off;
    logic set_flag;
    logic drive_hi;
    logic drive_lo;
    logic pulse;
  } tcu_act_t;
endpackage

// File: rtl/tcu_cmp_core.sv
module tcu_cmp_core #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic [W-1:0] tmr_val,
  output logic         hit
);
  logic [W-1:0] cmp_q;
  logic         eq_now;
  logic         eq_prev;

  assign eq_now = (tmr_val == cmp_q);
  assign hit    = eq_now & ~eq_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_q   <= '0;
      eq_prev <= 1'b0;
    end else begin
      eq_prev <= eq_now;
      if (wr_en) cmp_q <= wr_data;
    end
  end
endmodule

// File: rtl/tcu_act_dec.sv
module tcu_act_dec
  import tcu_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  input  logic              hit,
  output tcu_act_t          act
);
  always_comb begin
    act = '0;
    if (mode == MD_OFF) begin
      act.force_off = 1'b1;
    end else if (hit) begin
      unique case (mode)
        MD_SET: begin act.set_flag = 1'b1; act.drive_hi = 1'b1; end
        MD_CLR: begin act.set_flag = 1'b1; act.drive_lo = 1'b1; end
        MD_SWI: act.set_flag = 1'b1;
        MD_EVT: begin act.set_flag = 1'b1; act.pulse = 1'b1; end
        default: act = '0;
      endcase
    end
  end
endmodule

// File: rtl/tcu_out_stage.sv
module tcu_out_stage
  import tcu_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  tcu_act_t act,
  input  logic     flag_clr,
  output logic     pin_q,
  output logic     flag_q,
  output logic     trig_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pin_q  <= 1'b0;
      flag_q <= 1'b0;
      trig_q <= 1'b0;
    end else begin
      trig_q <= act.pulse;
      if (act.force_off) begin
        pin_q  <= 1'b0;
        flag_q <= 1'b0;
      end else begin
        if (act.drive_hi)      pin_q <= 1'b1;
        else if (act.drive_lo) pin_q <= 1'b0;
        if (act.set_flag)      flag_q <= 1'b1;
        else if (flag_clr)     flag_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tmr_cmp_unit.sv
module tmr_cmp_unit
  import tcu_pkg::*;
#(
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TMR_W-1:0] tmr_val,
  input  logic             cmp_wr_en,
  input  logic [TMR_W-1:0] cmp_wr_data,
  input  logic             mode_wr_en,
  input  logic [3:0]       mode_wr_data,
  input  logic             flag_clr,
  output logic             pin_out,
  output logic             irq_flag,
  output logic             evt_trig
);
  logic [MODE_W-1:0] mode_q;
  logic              hit;
  tcu_act_t          act;

  always_ff @(posedge clk) begin
    if (!rst_n)          mode_q <= MD_OFF;
    else if (mode_wr_en) mode_q <= mode_wr_data;
  end

  tcu_cmp_core #(.W(TMR_W)) u_core (
    .clk(clk), .rst_n(rst_n), .wr_en(cmp_wr_en), .wr_data(cmp_wr_data),
    .tmr_val(tmr_val), .hit(hit)
  );

  tcu_act_dec u_dec (.mode(mode_q), .hit(hit), .act(act));

  tcu_out_stage u_out (
    .clk(clk), .rst_n(rst_n), .act(act), .flag_clr(flag_clr),
    .pin_q(pin_out), .flag_q(irq_flag), .trig_q(evt_trig)
  );
endmodule

// File: rtl/tmr_cmp_unit_chk.sv
module tmr_cmp_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] mode_q,
  input logic       pin_out,
  input logic       irq_flag,
  input logic       evt_trig
);
  // R5
  trig_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_trig |=> !evt_trig);

  // R5
  trig_with_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_trig |-> irq_flag);

  // R7
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 4'b0000) |=> (!pin_out && !irq_flag && !evt_trig));

  // R4
  swi_pin_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 4'b1010) |=> $stable(pin_out));

  // R8
  idle_mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != 4'b0000 && mode_q[3:2] != 2'b10) |=> ($stable(pin_out) && !evt_trig));
endmodule

bind tmr_cmp_unit tmr_cmp_unit_chk chk_i (
  .clk(clk), .rst_n(rst_n), .mode_q(mode_q),
  .pin_out(pin_out), .irq_flag(irq_flag), .evt_trig(evt_trig)
);

// File: tb/tmr_cmp_unit_tb_top.sv
module tmr_cmp_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYCLES = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] tmr_val = '0;
  logic        cmp_wr_en = 1'b0;
  logic [15:0] cmp_wr_data = '0;
  logic        mode_wr_en = 1'b0;
  logic [3:0]  mode_wr_data = '0;
  logic        flag_clr = 1'b0;
  logic        pin_out, irq_flag, evt_trig;

  int vectors = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  // reference state
  logic [15:0] r_cmp = '0;
  logic [3:0]  r_mode = '0;
  logic        r_prev = 1'b0;
  logic        r_pin = 1'b0, r_flag = 1'b0, r_trig = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cycles++;

  tmr_cmp_unit dut_i (
    .clk(clk), .rst_n(rst_n), .tmr_val(tmr_val), .cmp_wr_en(cmp_wr_en),
    .cmp_wr_data(cmp_wr_data), .mode_wr_en(mode_wr_en), .mode_wr_data(mode_wr_data),
    .flag_clr(flag_clr), .pin_out(pin_out), .irq_flag(irq_flag), .evt_trig(evt_trig)
  );

  function automatic bit is_hit(input logic [15:0] t);
    return (t == r_cmp) && !r_prev;
  endfunction

  task automatic ref_update();
    bit h;
    h = is_hit(tmr_val);
    r_prev = (tmr_val == r_cmp);
    r_trig = 1'b0;
    if (r_mode == 4'b0000) begin
      r_pin = 1'b0; r_flag = 1'b0;
    end else begin
      if (flag_clr) r_flag = 1'b0;
      if (h && r_mode[3:2] == 2'b10) begin
        r_flag = 1'b1;
        case (r_mode[1:0])
          2'd0: r_pin = 1'b1;
          2'd1: r_pin = 1'b0;
          2'd3: r_trig = 1'b1;
          default: ;
        endcase
      end
    end
    if (cmp_wr_en)  r_cmp  = cmp_wr_data;
    if (mode_wr_en) r_mode = mode_wr_data;
  endtask

  task automatic check(input string tag);
    vectors++;
    if ({pin_out, irq_flag, evt_trig} !== {r_pin, r_flag, r_trig}) begin
      errors++;
      $display("FAIL %s: pin/flag/trig actual %b%b%b expected %b%b%b",
               tag, pin_out, irq_flag, evt_trig, r_pin, r_flag, r_trig);
    end
  endtask

  task automatic step(input logic [15:0] t, input logic cw, input logic [15:0] cd,
                      input logic mw, input logic [3:0] md, input logic fc, input string tag);
    @(negedge clk);
    tmr_val = t; cmp_wr_en = cw; cmp_wr_data = cd;
    mode_wr_en = mw; mode_wr_data = md; flag_clr = fc;
    @(posedge clk);
    ref_update();
    #1;
    check(tag);
  endtask

  task automatic tick(input logic [15:0] t, input logic fc, input string tag);
    step(t, 1'b0, 16'h0, 1'b0, 4'h0, fc, tag);
  endtask

  task automatic set_mode(input logic [3:0] md, input logic [15:0] t, input string tag);
    step(t, 1'b0, 16'h0, 1'b1, md, 1'b0, tag);
  endtask

  initial begin
    while (!done && cycles < MAX_CYCLES) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual cycles %0d expected < %0d", cycles, MAX_CYCLES);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 reset");
    // R1: compare register is 0 after reset, so a timer value of 0 matches.
    set_mode(4'b1000, 16'd5, "R1 mode load");
    tick(16'd0, 1'b0, "R1 reset compare value");
    // R10: the write alone must not move the pin.
    step(16'd7, 1'b1, 16'd100, 1'b1, 4'b1001, 1'b0, "R10 write no pin change");
    tick(16'd99, 1'b0, "R10 compare not yet hit");
    // R3
    tick(16'd100, 1'b0, "R3 clear on match");
    set_mode(4'b1000, 16'd101, "R2 mode set");
    tick(16'd100, 1'b1, "R2 set on match");
    // R6: hold the equality and clear the flag; it must stay clear.
    tick(16'd100, 1'b1, "R6 clear during held match");
    tick(16'd100, 1'b0, "R6 no re-fire");
    // R4
    set_mode(4'b1010, 16'd0, "R4 mode swi");
    tick(16'd0, 1'b1, "R4 flag cleared");
    tick(16'd100, 1'b0, "R4 flag only");
    // R5
    set_mode(4'b1011, 16'd1, "R5 mode evt");
    tick(16'd100, 1'b1, "R5 pulse");
    tick(16'd100, 1'b0, "R5 pulse one cycle");
    tick(16'd0, 1'b0, "R5 pulse ended");
    // R9: clear in the same cycle as a new match keeps the flag set.
    tick(16'd100, 1'b1, "R9 match beats clear");
    tick(16'd3, 1'b1, "R9 clear");
    // R8
    set_mode(4'b1000, 16'd4, "R8 prep");
    tick(16'd100, 1'b0, "R8 prep pin high");
    step(16'd5, 1'b0, 16'h0, 1'b1, 4'b0110, 1'b1, "R8 enter idle mode");
    tick(16'd100, 1'b0, "R8 no action in 0110");
    set_mode(4'b1101, 16'd6, "R8 mode 1101");
    tick(16'd100, 1'b0, "R8 no action in 1101");
    // R10: a new compare value while the pin is high leaves the pin.
    set_mode(4'b1000, 16'd7, "R10 prep");
    step(16'd8, 1'b1, 16'd200, 1'b0, 4'h0, 1'b0, "R10 pin held over write");
    tick(16'd200, 1'b0, "R10 new value matches");
    // R7
    set_mode(4'b0000, 16'd9, "R7 off");
    tick(16'd200, 1'b0, "R7 pin low flag clear");
    tick(16'd10, 1'b0, "R7 off");
    tick(16'd200, 1'b0, "R7 match ignored");

    // constrained random phase
    for (int i = 0; i < 4000; i++) begin
      logic [15:0] t;
      int sel;
      sel = $urandom_range(0, 9);
      if (sel < 4)      t = r_cmp;
      else if (sel < 7) t = r_cmp + 16'($urandom_range(1, 3));
      else              t = 16'($urandom);
      step(t,
           ($urandom_range(0, 19) == 0), 16'($urandom_range(0, 7)),
           ($urandom_range(0, 11) == 0), ($urandom_range(0, 3) == 0) ? 4'($urandom) : (4'b1000 | 4'($urandom_range(0, 3))),
           ($urandom_range(0, 5) == 0), "RND R2-mix");
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule